// File: doc/BRIEF.md
# Free-Running-Clock SPI Master Transmitter

This block is an SPI master shift engine for an 8-bit transfer. Its serial bit clock comes from a divider of the system clock that runs continuously whenever the block is both enabled and set to master. A write from the bus side loads a byte and arms the engine. The first SCK edge is then produced at the next bit-clock boundary of that divider. The divider is not restarted by the write, so the latency from write to first edge depends on where the write falls within the current bit period.

The bus side drives a data write strobe with a byte, an enable, a master select, a two-bit rate select, and clock phase and polarity settings. The serial side drives SCK and MOSI and samples MISO. After the last of the 16 SCK edges of a transfer, the received byte appears on `rx_data_o` and a level flag `done_o` is raised. Software-side register decoding is left to the surrounding logic.

Top module: `spi_freerun_tx`

## Requirements
- R1: The divider counts only while `cfg_en_i` and `cfg_master_i` are both 1, and holds at zero otherwise. A write while either is 0 is ignored: SCK stays idle and no transfer starts later.
- R2: The rate select sets SCK period to 2, 8, 32 or 128 clock cycles for codes 0, 1, 2 and 3. Each SCK half period is half of that.
- R3: Count the clock edges with the block active as j = 0, 1, 2 and so on. The first SCK edge falls on the first edge j after the write edge for which j mod ratio = ratio-1. The first SCK edge therefore follows the write edge by 1 to ratio cycles, and there are ratio distinct possible delays.
- R4: Data leaves MOSI most significant bit first: bit 7, then bit 6, and so on down to bit 0.
- R5: With `cfg_cpha_i`=0, MOSI carries bit 7 from the cycle after the write, before the first SCK edge. MISO is sampled on SCK edges 1, 3, 5 and so on. MOSI changes on edges 2, 4, 6 and so on.
- R6: With `cfg_cpha_i`=1, MOSI changes on SCK edges 1, 3, 5 and so on. MISO is sampled on edges 2, 4, 6 and so on.
- R7: A transfer has exactly 16 SCK edges. On the 16th edge, `rx_data_o` takes the received byte (first sampled bit in bit 7) and `done_o` goes to 1. An accepted write clears `done_o`.
- R8: A write while a transfer is armed or running is ignored. The byte being sent and the byte received are unchanged.
- R9: When no transfer is running, SCK equals `cfg_cpol_i`. Between transfers, MOSI holds the last bit it drove.
- R10: Clearing the enable aborts a transfer. SCK is idle and `done_o` is 0 from the next cycle, and the divider restarts from zero on the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Block enable |
| cfg_master_i | input | 1 | Master select |
| cfg_rate_i | input | 2 | Rate code: 0 gives /2, 1 gives /8, 2 gives /32, 3 gives /128 |
| cfg_cpha_i | input | 1 | Clock phase |
| cfg_cpol_i | input | 1 | Idle level of SCK |
| wr_valid_i | input | 1 | Data register write strobe |
| wr_data_i | input | 8 | Byte to send |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| rx_data_o | output | 8 | Last received byte |
| done_o | output | 1 | Transfer complete flag |

## Verification
On every cycle, the assertions check several properties. SCK is at rest whenever no transfer is running. The divider is held at zero while the block is inactive. A transfer starts only on a bit-clock boundary, and the armed wait never grows past the longest bit time. Disabling the block aborts the transfer, and the transmit byte stays untouched between SCK edges, so a mid-transfer write cannot disturb it. The bench scenarios cover what needs arithmetic over a whole transfer. The scenarios show the exact cycle of every SCK edge for each rate, and that a sweep of write offsets produces as many distinct start delays as the divide ratio. They also show the MOSI bit order for both phase settings, the received byte, and timing that starts afresh after an abort.

// File: rtl/spi_fr_pkg.sv
`timescale 1ns/1ps
package spi_fr_pkg;
  localparam int unsigned NUM_RATES = 4;
  localparam int unsigned CNT_W     = 2 * NUM_RATES - 1;  // log2 of the slowest ratio
  localparam int unsigned MAX_RATIO = 1 << CNT_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } eng_st_e;

  // code n selects divide ratio 2^(2n+1)
  function automatic int unsigned rate_log2(input int unsigned code);
    return 2 * code + 1;
  endfunction
endpackage

// File: rtl/spi_fr_div.sv
`timescale 1ns/1ps
module spi_fr_div
  import spi_fr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       lead_o,
  output logic       half_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] full_m [NUM_RATES];
  logic [CNT_W-1:0] half_m [NUM_RATES];

  for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_mask
    assign full_m[gi] = CNT_W'((1 << rate_log2(gi)) - 1);
    assign half_m[gi] = CNT_W'((1 << (rate_log2(gi) - 1)) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // lead: last cycle of a bit period; half: last cycle of a half period
  assign lead_o = run_i && ((cnt_q & full_m[rate_i]) == full_m[rate_i]);
  assign half_o = run_i && ((cnt_q & half_m[rate_i]) == half_m[rate_i]);

  p_div_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_fr_engine.sv
`timescale 1ns/1ps
module spi_fr_engine
  import spi_fr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              lead_i,
  input  logic              half_i,
  input  logic              cpha_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              miso_i,
  output logic              sck_ph_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o
);
  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES) + 1;
  localparam int unsigned LAST   = EDGES - 1;

  eng_st_e           st_q;
  logic [EDGE_W-1:0] edge_q, k;
  logic [DATA_W-1:0] tx_q, rx_q, rx_nxt, rx_data_q;
  logic              sck_q, mosi_q, done_q;
  logic              ev, smp, shf, last;

  always_comb begin
    ev     = (st_q == ST_ARMED && lead_i) || (st_q == ST_RUN && half_i);
    k      = (st_q == ST_RUN) ? edge_q : '0;
    last   = (k == EDGE_W'(LAST));
    smp    = cpha_i ? k[0] : ~k[0];
    shf    = cpha_i ? ~k[0] : (k[0] & ~last);
    rx_nxt = smp ? {rx_q[DATA_W-2:0], miso_i} : rx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      edge_q    <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      rx_data_q <= '0;
      sck_q     <= 1'b0;
      mosi_q    <= 1'b0;
      done_q    <= 1'b0;
    end else if (!active_i) begin
      st_q   <= ST_IDLE;
      edge_q <= '0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (wr_valid_i) begin
          st_q   <= ST_ARMED;
          done_q <= 1'b0;
          if (cpha_i) tx_q <= wr_data_i;
          else begin
            tx_q   <= {wr_data_i[DATA_W-2:0], 1'b0};
            mosi_q <= wr_data_i[DATA_W-1];
          end
        end
        default: if (ev) begin
          sck_q  <= ~sck_q;
          rx_q   <= rx_nxt;
          edge_q <= k + EDGE_W'(1);
          if (shf) begin
            mosi_q <= tx_q[DATA_W-1];
            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
          end
          if (last) begin
            st_q      <= ST_IDLE;
            done_q    <= 1'b1;
            rx_data_q <= rx_nxt;
          end else begin
            st_q <= ST_RUN;
          end
        end
      endcase
    end
  end

  assign sck_ph_o  = sck_q;
  assign mosi_o    = mosi_q;
  assign rx_data_o = rx_data_q;
  assign done_o    = done_q;

  // armed-wait counter, checking only
  logic [CNT_W:0] wait_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               wait_q <= '0;
    else if (st_q == ST_ARMED) wait_q <= wait_q + 1'b1;
    else                       wait_q <= '0;
  end

  p_idle_sck_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RUN) |-> !sck_q);
  p_start_on_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && $past(st_q) == ST_ARMED) |-> $past(lead_i));
  p_wait_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q < (CNT_W+1)'(MAX_RATIO));
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (st_q == ST_IDLE && !done_q && !sck_q));
  p_done_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(st_q) == ST_RUN));
  p_tx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && active_i && !ev) |=> $stable(tx_q));
endmodule

// File: rtl/spi_freerun_tx.sv
`timescale 1ns/1ps
module spi_freerun_tx
  import spi_fr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_master_i,
  input  logic [1:0]        cfg_rate_i,
  input  logic              cfg_cpha_i,
  input  logic              cfg_cpol_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o
);
  logic active, lead, half, sck_ph;

  assign active = cfg_en_i & cfg_master_i;

  spi_fr_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .rate_i (cfg_rate_i),
    .lead_o (lead),
    .half_o (half)
  );

  spi_fr_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .lead_i     (lead),
    .half_i     (half),
    .cpha_i     (cfg_cpha_i),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .miso_i     (miso_i),
    .sck_ph_o   (sck_ph),
    .mosi_o     (mosi_o),
    .rx_data_o  (rx_data_o),
    .done_o     (done_o)
  );

  assign sck_o = sck_ph ^ cfg_cpol_i;
endmodule

// File: tb/test_spi_freerun_tx.sv
`timescale 1ns/1ps
module test_spi_freerun_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, mst = 1'b0, cpha = 1'b0, cpol = 1'b0, wr = 1'b0, miso = 1'b0;
  logic [1:0] rate = 2'd0;
  logic [7:0] wdat = 8'd0;
  logic       sck, mosi, done;
  logic [7:0] rxd;
  int         cyc = 0;
  int         total = 0, bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_freerun_tx i_spi_freerun_tx (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_master_i(mst),
    .cfg_rate_i(rate), .cfg_cpha_i(cpha), .cfg_cpol_i(cpol),
    .wr_valid_i(wr), .wr_data_i(wdat), .miso_i(miso),
    .sck_o(sck), .mosi_o(mosi), .rx_data_o(rxd), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one full transfer; returns cycles from write edge to first SCK edge
  task automatic xfer(input int r, input bit ph, input bit pol, input logic [7:0] tx,
                      input logic [7:0] rv, input int woff, input bit inj, output int delay);
    int ratio, half, c0, cw, jw, jf, first, k, tmis, dmis, guard, t_act, t_exp;
    bit prev, wr_pend;
    ratio = 2 << (2 * r);
    half  = ratio / 2;
    @(negedge clk);
    en = 1'b0; mst = 1'b1; rate = 2'(r); cpha = ph; cpol = pol;
    @(negedge clk);
    chk(sck == pol, "R9 idle sck level", sck, pol);
    en = 1'b1; c0 = cyc;
    repeat (woff) @(negedge clk);
    cw = cyc; wr = 1'b1; wdat = tx;
    if (!ph) miso = rv[7];
    @(negedge clk);
    wr = 1'b0;
    if (!ph) chk(mosi == tx[7], "R5 msb on mosi before first edge", mosi, tx[7]);
    jw = cw - c0;
    jf = jw + 1;
    while (jf % ratio != ratio - 1) jf++;
    first = c0 + 1 + jf;
    delay = first - (cw + 1);
    k = 0; prev = pol; tmis = 0; dmis = 0; guard = 0; wr_pend = 1'b0;
    t_act = 0; t_exp = 0;
    while (k < 16 && guard < 20 * ratio + 100) begin
      @(negedge clk);
      guard++;
      if (wr_pend) begin wr = 1'b0; wr_pend = 1'b0; end
      if (sck != prev) begin
        prev = sck;
        if (cyc != first + k * half && tmis == 0) begin
          t_act = cyc; t_exp = first + k * half;
          tmis++;
        end
        if (!k[0] && mosi != tx[7 - k/2]) dmis++;
        if (!ph && k[0] && k < 15) miso = rv[7 - (k+1)/2];
        if (ph && !k[0]) miso = rv[7 - k/2];
        if (inj && k == 5) begin wr = 1'b1; wdat = ~tx; wr_pend = 1'b1; end
        k++;
      end
    end
    chk(k == 16, "R7 sixteen sck edges", k, 16);
    chk(tmis == 0, ph ? "R2 R3 R6 edge timing" : "R2 R3 R5 edge timing", t_act, t_exp);
    chk(dmis == 0, "R4 msb-first mosi order", dmis, 0);
    chk(done == 1'b1, "R7 done after last edge", done, 1);
    chk(rxd == rv, ph ? "R6 received byte" : "R5 received byte", rxd, rv);
    chk(sck == pol, "R9 sck back to idle", sck, pol);
    repeat (ratio + 2) @(negedge clk);
    chk(mosi == tx[0] && sck == pol, "R9 mosi holds, sck idle", {sck, mosi}, {pol, tx[0]});
    chk(done == 1'b1, inj ? "R8 no extra transfer after ignored write" : "R7 done holds", done, 1);
  endtask

  initial begin
    #4000000;
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d;
    bit [255:0] seen;
    int nseen;
    repeat (3) @(negedge clk);
    chk(sck == 1'b0, "R9 reset sck", sck, 0);
    chk(mosi == 1'b0, "R9 reset mosi", mosi, 0);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(rxd == 8'd0, "R7 reset rx_data", rxd, 0);
    rst_n = 1'b1;

    // ratio 2: every offset, both phases
    for (int ph = 0; ph < 2; ph++)
      for (int w = 0; w < 2; w++) begin
        xfer(0, 1'(ph), 1'(w), 8'hA5 ^ 8'(w*16 + ph), 8'h3C ^ 8'(ph*3 + w), w, 1'b0, d);
        chk(d >= 1 && d <= 2, "R3 start delay within one bit time", d, 2);
      end

    // ratio 8: sweep write offsets, count distinct start delays
    seen = '0; nseen = 0;
    for (int w = 0; w < 8; w++) begin
      xfer(1, 1'(w & 1), 1'((w >> 1) & 1), 8'(8'h81 + w*23), 8'(8'h5A ^ (w*37)), w, 1'b0, d);
      chk(d >= 1 && d <= 8, "R3 start delay within one bit time", d, 8);
      if (!seen[d]) begin seen[d] = 1'b1; nseen++; end
    end
    chk(nseen == 8, "R3 distinct start points equal ratio", nseen, 8);

    xfer(2, 1'b0, 1'b1, 8'hC3, 8'h96, 13, 1'b0, d);
    chk(d >= 1 && d <= 32, "R3 start delay ratio 32", d, 32);
    xfer(3, 1'b1, 1'b0, 8'h1E, 8'hE1, 77, 1'b0, d);
    chk(d >= 1 && d <= 128, "R3 start delay ratio 128", d, 128);

    // write during a running transfer
    xfer(1, 1'b0, 1'b0, 8'h6D, 8'hB2, 2, 1'b1, d);
    xfer(1, 1'b1, 1'b1, 8'h92, 8'h4F, 5, 1'b1, d);

    // clearing enable after completion drops done
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R10 done cleared by disable", done, 0);

    // not master: write ignored
    cpol = 1'b0; rate = 2'd0; cpha = 1'b0;
    en = 1'b1; mst = 1'b0;
    @(negedge clk); wr = 1'b1; wdat = 8'hFF;
    @(negedge clk); wr = 1'b0;
    begin
      int chg = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (i == 20) mst = 1'b1;
        if (sck != 1'b0) chg++;
      end
      chk(chg == 0, "R1 no sck activity for write while not master", chg, 0);
      chk(done == 1'b0, "R1 no completion for ignored write", done, 0);
    end

    // abort mid-transfer, then restart with fresh divider timing
    @(negedge clk); en = 1'b0; rate = 2'd1; cpol = 1'b1; cpha = 1'b0;
    @(negedge clk); en = 1'b1;
    @(negedge clk); wr = 1'b1; wdat = 8'h55;
    @(negedge clk); wr = 1'b0;
    begin
      int edges = 0;
      bit p = 1'b1;
      for (int i = 0; i < 200 && edges < 5; i++) begin
        @(negedge clk);
        if (sck != p) begin p = sck; edges++; end
      end
      chk(edges == 5, "R10 transfer under way before abort", edges, 5);
    end
    en = 1'b0;
    @(negedge clk);
    chk(sck == 1'b1, "R10 sck idle after abort", sck, 1);
    chk(done == 1'b0, "R10 done low after abort", done, 0);
    xfer(1, 1'b0, 1'b1, 8'hE7, 8'h18, 3, 1'b0, d);
    chk(d == 4, "R10 divider restarts from zero", d, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule